// File: doc/BRIEF.md
# Immediate-Operand Data-Processing ALU

This block executes one register-with-immediate data-processing operation per cycle. A 32-bit first operand is combined with an immediate that the block builds itself: an 8-bit value is zero-extended and rotated right by twice a 4-bit rotate field. A 4-bit opcode selects one of sixteen operations. The operations fall into three groups: bitwise, add-type and subtract-type. Four of the opcodes only compare or test and write no result. The block produces the 32-bit result, a write enable for the destination, and the next negative, zero, carry and overflow flags.

The result and the next flags are combinational. A flag register holds the current flags and feeds them back into the datapath. It loads the next flags on a clock edge when the update strobe is high. The next flags equal the current flags whenever the set-flags input is low. Conditional execution, register-file access and pipeline control belong to the surrounding core.

Top module: `imm_alu_top`

## Requirements
- R1: The immediate used by every opcode is `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot` bit positions. With opcode 0xD (move) the result equals this value.
- R2: Results by opcode: 0x0 op_a AND imm, 0x1 op_a XOR imm, 0x2 op_a−imm, 0x3 imm−op_a, 0x4 op_a+imm, 0xC op_a OR imm, 0xD imm, 0xE op_a AND NOT imm, 0xF NOT imm.
- R3: Opcode 0x5 gives op_a+imm+C. Opcode 0x6 gives op_a−imm−(NOT C). Opcode 0x7 gives imm−op_a−(NOT C). C is the current carry flag.
- R4: `result_we` is 0 for opcodes 0x8 (AND test), 0x9 (XOR test), 0xA (subtract compare) and 0xB (add compare), and 1 for every other opcode.
- R5: With `set_flags` = 0, `flags_next` equals `flags_q`, so an update leaves the flags unchanged.
- R6: With `set_flags` = 1, the next N is bit 31 of the computed value and the next Z is 1 exactly when all 32 bits are zero. This holds for all opcodes, including the four that write no result.
- R7: For the bitwise opcodes (0x0, 0x1, 0x8, 0x9, 0xC, 0xD, 0xE, 0xF), the next C is bit 31 of the rotated immediate when `imm_rot` is nonzero and otherwise the old C. The next V is always the old V.
- R8: For the add-type opcodes (0x4, 0x5, 0xB), C is the unsigned carry-out and V the signed overflow. For the subtract-type opcodes (0x2, 0x3, 0x6, 0x7, 0xA), C is 1 when no borrow occurs and V is the signed overflow, with operands in each opcode's order.
- R9: `flags_q` packs the flags as [3]=N, [2]=Z, [1]=C, [0]=V. It resets to 0 and loads `flags_next` on a rising clock edge only while `flag_upd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| imm_byte | input | 8 | Immediate value before rotation |
| imm_rot | input | 4 | Rotate field, amount is twice this value |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Let the operation produce new flags |
| flag_upd | input | 1 | Load the flag register this cycle |
| result | output | 32 | Computed value |
| result_we | output | 1 | Destination write enable |
| flags_next | output | 4 | Next flags, N Z C V |
| flags_q | output | 4 | Registered flags, N Z C V |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit immediate and 4-bit rotate field. With these widths every rotate amount from 0 to 30 can be reached, including the amounts that move the byte across bit 31 and produce a rotator carry. The default widths also make the adder's 32-bit carry and overflow boundaries reachable from directed operands such as 0xFFFFFFFF and 0x7FFFFFFF. Random opcode, flag and strobe mixes then run the carry-in opcodes against every carry value the earlier operations leave behind.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND    = 4'h0,
        OP_XOR    = 4'h1,
        OP_SUB    = 4'h2,
        OP_RSUB   = 4'h3,
        OP_ADD    = 4'h4,
        OP_ADDC   = 4'h5,
        OP_SUBC   = 4'h6,
        OP_RSUBC  = 4'h7,
        OP_TEST   = 4'h8,
        OP_TESTEQ = 4'h9,
        OP_CMP    = 4'hA,
        OP_CMPNEG = 4'hB,
        OP_OR     = 4'hC,
        OP_MOVE   = 4'hD,
        OP_ANDN   = 4'hE,
        OP_MOVEN  = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2
    } op_class_e;

endpackage

// File: rtl/imm_rotator.sv
module imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    output logic [DATA_W-1:0] imm_val,
    output logic              rot_carry,
    output logic              rot_nz
);
    localparam int AMT_W = ROT_W + 1;

    logic [DATA_W-1:0]   ext;
    logic [AMT_W-1:0]    amt;
    logic [2*DATA_W-1:0] wide;

    always_comb begin
        ext       = {{(DATA_W-IMM_W){1'b0}}, imm_byte};
        amt       = {imm_rot, 1'b0};
        wide      = {ext, ext} >> amt;
        imm_val   = wide[DATA_W-1:0];
        rot_carry = imm_val[DATA_W-1];
        rot_nz    = |imm_rot;
    end
endmodule

// File: rtl/imm_addsub.sv
module imm_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        sum  = full[DATA_W-1:0];
        cout = full[DATA_W];
        ovf  = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
    import imm_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  flags_t            flags_cur,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output flags_t            flags_next
);
    logic [DATA_W-1:0] imm_val;
    logic              rot_carry;
    logic              rot_nz;

    logic [DATA_W-1:0] add_a, add_b, add_sum;
    logic              add_cin, add_cout, add_ovf;
    logic [DATA_W-1:0] logic_val;
    op_class_e         cls;
    alu_op_e           op;

    imm_rotator #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .imm_val  (imm_val),
        .rot_carry(rot_carry),
        .rot_nz   (rot_nz)
    );

    imm_addsub #(.DATA_W(DATA_W)) u_adder (
        .a   (add_a),
        .b   (add_b),
        .cin (add_cin),
        .sum (add_sum),
        .cout(add_cout),
        .ovf (add_ovf)
    );

    // Operand steering: subtraction is a + ~b + carry-in
    always_comb begin
        op        = alu_op_e'(opcode);
        add_a     = op_a;
        add_b     = imm_val;
        add_cin   = 1'b0;
        logic_val = '0;
        cls       = CLS_LOGIC;
        unique case (op)
            OP_AND, OP_TEST:   logic_val = op_a & imm_val;
            OP_XOR, OP_TESTEQ: logic_val = op_a ^ imm_val;
            OP_OR:             logic_val = op_a | imm_val;
            OP_MOVE:           logic_val = imm_val;
            OP_ANDN:           logic_val = op_a & ~imm_val;
            OP_MOVEN:          logic_val = ~imm_val;
            OP_ADD, OP_CMPNEG: cls = CLS_ADD;
            OP_ADDC: begin
                cls     = CLS_ADD;
                add_cin = flags_cur.carry;
            end
            OP_SUB, OP_CMP: begin
                cls     = CLS_SUB;
                add_b   = ~imm_val;
                add_cin = 1'b1;
            end
            OP_SUBC: begin
                cls     = CLS_SUB;
                add_b   = ~imm_val;
                add_cin = flags_cur.carry;
            end
            OP_RSUB: begin
                cls     = CLS_SUB;
                add_a   = imm_val;
                add_b   = ~op_a;
                add_cin = 1'b1;
            end
            OP_RSUBC: begin
                cls     = CLS_SUB;
                add_a   = imm_val;
                add_b   = ~op_a;
                add_cin = flags_cur.carry;
            end
        endcase
    end

    // Result, write enable and flag generation
    always_comb begin
        result    = (cls == CLS_LOGIC) ? logic_val : add_sum;
        result_we = (opcode[3:2] != 2'b10);
        flags_next = flags_cur;
        if (set_flags) begin
            flags_next.neg  = result[DATA_W-1];
            flags_next.zero = (result == '0);
            if (cls == CLS_LOGIC) begin
                if (rot_nz) flags_next.carry = rot_carry;
            end else begin
                flags_next.carry = add_cout;
                flags_next.ovf   = add_ovf;
            end
        end
    end
endmodule

// File: rtl/imm_alu_top.sv
module imm_alu_top
    import imm_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic              flag_upd,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [3:0]        flags_next,
    output logic [3:0]        flags_q
);
    flags_t flag_reg;
    flags_t flag_nxt;

    imm_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_core (
        .op_a      (op_a),
        .imm_byte  (imm_byte),
        .imm_rot   (imm_rot),
        .opcode    (opcode),
        .set_flags (set_flags),
        .flags_cur (flag_reg),
        .result    (result),
        .result_we (result_we),
        .flags_next(flag_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_reg <= '0;
        else if (flag_upd) flag_reg <= flag_nxt;
    end

    always_comb begin
        flags_next = flag_nxt;
        flags_q    = flag_reg;
    end
endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
    parameter int DATA_W = 32,
    parameter int ROT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROT_W-1:0]  imm_rot,
    input logic [3:0]        opcode,
    input logic              set_flags,
    input logic              flag_upd,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic [3:0]        flags_q
);
    logic is_logic;
    assign is_logic = (opcode == 4'h0) || (opcode == 4'h1) || (opcode == 4'h8) ||
                      (opcode == 4'h9) || (opcode >= 4'hC);

    assert_test_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |-> !result_we);

    assert_other_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] != 2'b10) |-> result_we);

    assert_no_set_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !set_flags) |=> $stable(flags_q));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd |=> $stable(flags_q));

    assert_nz_from_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && set_flags && result_we) |=>
            (flags_q[3] == $past(result[DATA_W-1])) && (flags_q[2] == ($past(result) == '0)));

    assert_logic_keep_cv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && set_flags && is_logic && (imm_rot == '0)) |=> $stable(flags_q[1:0]));

    assert_logic_keep_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && set_flags && is_logic) |=> $stable(flags_q[0]));
endmodule

bind imm_alu_top imm_alu_chk #(.DATA_W(DATA_W), .ROT_W(ROT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm_rot  (imm_rot),
    .opcode   (opcode),
    .set_flags(set_flags),
    .flag_upd (flag_upd),
    .result   (result),
    .result_we(result_we),
    .flags_q  (flags_q)
);

// File: tb/test_imm_alu_top.sv
module test_imm_alu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic        flag_upd = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_next;
    logic [3:0]  flags_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] mflags = 4'h0;

    imm_alu_top i_imm_alu_top (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .imm_byte(imm_byte), .imm_rot(imm_rot),
        .opcode(opcode), .set_flags(set_flags), .flag_upd(flag_upd),
        .result(result), .result_we(result_we), .flags_next(flags_next), .flags_q(flags_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference: flags packed N Z C V
    function automatic void model(input logic [31:0] a, input logic [7:0] iv, input logic [3:0] rv,
                                  input logic [3:0] oc, input logic sf, input logic [3:0] fin,
                                  output logic [31:0] res, output logic we, output logic [3:0] fout);
        longint unsigned x, r, s;
        longint sv;
        int sh, mode;
        logic [31:0] iw, p, q;
        logic c, v, k;
        sh = 2 * int'(rv);
        x  = longint'(iv);
        r  = ((x >> sh) | (x << (32 - sh))) & 64'hFFFF_FFFF;
        iw = r[31:0];
        c = fin[1]; v = fin[0];
        we = !(oc >= 4'h8 && oc <= 4'hB);
        mode = 0; p = a; q = iw; k = 1'b0; res = '0;
        case (oc)
            4'h0, 4'h8: res = a & iw;
            4'h1, 4'h9: res = a ^ iw;
            4'hC: res = a | iw;
            4'hD: res = iw;
            4'hE: res = a & ~iw;
            4'hF: res = ~iw;
            4'h4, 4'hB: mode = 1;
            4'h5: begin mode = 1; k = fin[1]; end
            4'h2, 4'hA: mode = 2;
            4'h3: begin mode = 2; p = iw; q = a; end
            4'h6: begin mode = 2; k = !fin[1]; end
            default: begin mode = 2; p = iw; q = a; k = !fin[1]; end
        endcase
        if (mode == 0) begin
            if (rv != 0) c = iw[31];
        end else if (mode == 1) begin
            s   = longint'(p) + longint'(q) + longint'(k);
            res = s[31:0];
            c   = s[32];
            sv  = longint'($signed(p)) + longint'($signed(q)) + longint'(k);
            v   = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        end else begin
            s   = longint'(p) - longint'(q) - longint'(k);
            res = s[31:0];
            c   = (longint'(p) >= longint'(q) + longint'(k));
            sv  = longint'($signed(p)) - longint'($signed(q)) - longint'(k);
            v   = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
        end
        fout = sf ? {res[31], (res == 32'h0), c, v} : fin;
    endfunction

    task automatic step(input string tag, input logic [31:0] a, input logic [7:0] iv,
                        input logic [3:0] rv, input logic [3:0] oc, input logic sf, input logic upd);
        logic [31:0] eres;
        logic        ewe;
        logic [3:0]  ef;
        @(negedge clk);
        op_a = a; imm_byte = iv; imm_rot = rv; opcode = oc; set_flags = sf; flag_upd = upd;
        #1;
        model(a, iv, rv, oc, sf, mflags, eres, ewe, ef);
        check({tag, " flags_q R9"}, 32'(flags_q), 32'(mflags));
        check({tag, " result_we R4"}, 32'(result_we), 32'(ewe));
        if (ewe) check({tag, " result R2"}, result, eres);
        check({tag, " flags_next R6"}, 32'(flags_next), 32'(ef));
        @(posedge clk);
        #1;
        if (upd) mflags = ef;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        check("reset flags R9", 32'(flags_q), 32'h0);
        rst_n = 1'b1;
        // R1 rotation cases through move
        step("R1 rot0",    32'h0, 8'hFF, 4'd0, 4'hD, 1'b1, 1'b1);
        step("R1 rot4 R7", 32'h0, 8'hFF, 4'd4, 4'hD, 1'b1, 1'b1);
        step("R1 rot1",    32'h0, 8'h03, 4'd1, 4'hD, 1'b1, 1'b1);
        step("R1 rot15",   32'h0, 8'h81, 4'd15, 4'hD, 1'b1, 1'b1);
        // R7 carry kept with zero rotate
        step("R7 keepc",   32'hF0F0F0F0, 8'h0F, 4'd0, 4'h0, 1'b1, 1'b1);
        // R2 bitwise and arithmetic results
        step("R2 xor",     32'h12345678, 8'hFF, 4'd0, 4'h1, 1'b0, 1'b1);
        step("R2 or",      32'h12345678, 8'hAB, 4'd8, 4'hC, 1'b0, 1'b0);
        step("R2 andn",    32'hFFFFFFFF, 8'h0F, 4'd2, 4'hE, 1'b1, 1'b1);
        step("R2 moven",   32'h0, 8'h00, 4'd0, 4'hF, 1'b1, 1'b1);
        // R8 adder boundaries
        step("R8 addwrap", 32'hFFFFFFFF, 8'h01, 4'd0, 4'h4, 1'b1, 1'b1);
        step("R8 addovf",  32'h7FFFFFFF, 8'h01, 4'd0, 4'h4, 1'b1, 1'b1);
        step("R8 subeq",   32'h5, 8'h05, 4'd0, 4'h2, 1'b1, 1'b1);
        step("R8 subbor",  32'h0, 8'h01, 4'd0, 4'h2, 1'b1, 1'b1);
        step("R8 rsub",    32'h10, 8'h04, 4'd0, 4'h3, 1'b1, 1'b1);
        // R3 carry-in opcodes with C known
        step("R3 setc",    32'hFFFFFFFF, 8'h01, 4'd0, 4'h4, 1'b1, 1'b1);
        step("R3 addc",    32'h10, 8'h01, 4'd0, 4'h5, 1'b0, 1'b0);
        step("R3 subc1",   32'h10, 8'h03, 4'd0, 4'h6, 1'b0, 1'b0);
        step("R3 clrc",    32'h0, 8'h01, 4'd0, 4'h2, 1'b1, 1'b1);
        step("R3 subc0",   32'hA, 8'h03, 4'd0, 4'h6, 1'b1, 1'b1);
        step("R3 rsubc",   32'h3, 8'h10, 4'd0, 4'h7, 1'b1, 1'b1);
        // R4 compare and test opcodes
        step("R4 cmp",     32'h8, 8'h08, 4'd0, 4'hA, 1'b1, 1'b1);
        step("R4 cmpneg",  32'hFFFFFFF8, 8'h08, 4'd0, 4'hB, 1'b1, 1'b1);
        step("R4 test",    32'h0F, 8'hF0, 4'd0, 4'h8, 1'b1, 1'b1);
        step("R4 testeq",  32'hFF000000, 8'hFF, 4'd4, 4'h9, 1'b1, 1'b1);
        // R5 set-flags clear, R9 strobe low
        step("R5 noset",   32'h0, 8'h00, 4'd0, 4'hD, 1'b0, 1'b1);
        step("R9 noupd",   32'h80000000, 8'h00, 4'd0, 4'hD, 1'b1, 1'b0);
        for (int i = 0; i < 400; i++) begin
            step("R2 R8 random", $urandom, 8'($urandom), 4'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom));
        end
        @(negedge clk);
        check("final flags R9", 32'(flags_q), 32'(mflags));
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule